// File: doc/BRIEF.md
# Fly-by DMA Transfer Engine

This block moves a block of words from a device controller's internal buffer into system memory so that the CPU does not have to copy it. The CPU first loads a target memory address and a byte count through a small register port. It then writes a start bit. From that point the engine runs the transfer by itself.

For each word, the engine raises a request to the device and drives the current memory address on its address lines. The device puts the word on the memory bus and memory takes it directly, so the data never passes through the engine. The device then acknowledges the word. On each acknowledge the engine moves the address forward by one word and lowers the remaining count. Once the count runs out, the engine interrupts the CPU.

If the device stops acknowledging, a watchdog ends the transfer and sets an error flag. The CPU reads a status register to learn the outcome, and that read also clears the interrupt.

Top module: `flyby_dma`

## Requirements
- R1: After synchronous reset, `dev_req` and `irq` are low, and the address, count and status registers all read as zero.
- R2: While the engine is idle, the CPU can write the memory address (select 0) and the byte count (select 1). Reading select 0 and select 1 returns the current live address and the remaining count. Select 2 always reads as zero.
- R3: Writing select 2 with bit 0 set, while idle and with a nonzero count, asserts `dev_req` from the next cycle, with `dev_addr` equal to the programmed address.
- R4: While `dev_req` is high and `dev_ack` is low, `dev_req` stays high and `dev_addr` holds its value, unless the watchdog of R10 expires.
- R5: Each cycle in which `dev_req` and `dev_ack` are both high adds 4 to the address. In the same cycle the count drops by 4, or goes to zero if 4 or fewer bytes remain.
- R6: The acknowledge that exhausts the count drops `dev_req` and clears busy in the next cycle, and sets the done flag and `irq`. A count that is not a multiple of 4 ends after the word that covers its last bytes.
- R7: A start with a count of zero raises `irq` and done in the next cycle, and never raises `dev_req`.
- R8: While busy, writes to the address, count and start registers have no effect on the running transfer or on the register values.
- R9: Status (select 3) reads bit 0 busy, bit 1 done and bit 2 error. A cycle with `cpu_rd` at select 3 clears `irq`. Done and error stay set until the next accepted start, which clears them.
- R10: If `dev_req` stays high for 64 cycles without `dev_ack`, the engine drops the request in the next cycle and clears busy. It also sets the error flag and `irq`, and the address and count keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe (has an effect only at select 3) |
| cpu_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| cpu_wdata | input | ADDR_W | CPU write data |
| cpu_rdata | output | ADDR_W | Combinational read data for the selected register |
| dev_req | output | 1 | Word request to the device controller |
| dev_addr | output | ADDR_W | Memory address for the current word |
| dev_ack | input | 1 | Device acknowledge for the current word |
| irq | output | 1 | Interrupt on completion or timeout |

## Verification
The transfer is run against a device that answers at once, one that answers after a few cycles of delay, and one that answers just inside the 64-cycle limit. These cases separate correct request holding from early or late stepping of the address and count. Counts that are multiples of the word size and counts that are not show whether the final partial word is taken and whether the count saturates at zero. A zero-count start, writes made in the middle of a transfer, and a device that never acknowledges each isolate one path: the immediate-completion path, the busy lock-out, and the watchdog abort.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    localparam int STAT_BITS = 3;

    typedef struct packed {
        logic err;
        logic done;
        logic busy;
    } stat_t;

    function automatic logic is_start(input logic wr, input logic [1:0] sel, input logic bit0);
        return wr && (sel == SEL_CTRL) && bit0;
    endfunction

endpackage

// File: rtl/flyby_dma_regs.sv
module flyby_dma_regs #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cnt_zero,
    output logic              cnt_last
);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q <= CNT_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ld_addr) begin
            addr_q <= addr_wdata;
        end else if (step) begin
            addr_q <= addr_q + ADDR_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld_cnt) begin
            cnt_q <= cnt_wdata;
        end else if (step) begin
            cnt_q <= cnt_last ? '0 : (cnt_q - CNT_STEP);
        end
    end

    assign cur_addr = addr_q;
    assign cur_cnt  = cnt_q;
endmodule

// File: rtl/flyby_dma_watchdog.sv
module flyby_dma_watchdog #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic expired
);
    localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT - 1);

    logic [TW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || !run || ack) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_q + 1'b1;
        end
    end

    assign expired = run && !ack && (wait_q == LIMIT);
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
    import flyby_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  stat_rd,
    input  logic  cnt_zero,
    input  logic  cnt_last,
    input  logic  ack,
    input  logic  expired,
    output logic  req,
    output logic  step,
    output stat_t stat,
    output logic  irq
);
    seq_state_e state_q;
    logic       done_q;
    logic       err_q;
    logic       irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (stat_rd) begin
                irq_q <= 1'b0;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= 1'b0;
                        if (cnt_zero) begin
                            done_q <= 1'b1;
                            irq_q  <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (ack) begin
                        if (cnt_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            irq_q   <= 1'b1;
                        end
                    end else if (expired) begin
                        state_q <= ST_IDLE;
                        err_q   <= 1'b1;
                        irq_q   <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req       = (state_q == ST_XFER);
    assign step      = req && ack;
    assign stat.busy = req;
    assign stat.done = done_q;
    assign stat.err  = err_q;
    assign irq       = irq_q;
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4,
    parameter int TIMEOUT    = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_sel,
    input  logic [ADDR_W-1:0] cpu_wdata,
    output logic [ADDR_W-1:0] cpu_rdata,
    output logic              dev_req,
    output logic [ADDR_W-1:0] dev_addr,
    input  logic              dev_ack,
    output logic              irq
);
    localparam int STAT_PAD = ADDR_W - STAT_BITS;
    localparam int CNT_PAD  = ADDR_W - CNT_W;

    logic              busy;
    logic              ld_addr;
    logic              ld_cnt;
    logic              start;
    logic              stat_rd;
    logic              step;
    logic              cnt_zero;
    logic              cnt_last;
    logic              expired;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    stat_t             stat;

    assign busy    = stat.busy;
    assign ld_addr = cpu_wr && (cpu_sel == SEL_ADDR)  && !busy;
    assign ld_cnt  = cpu_wr && (cpu_sel == SEL_COUNT) && !busy;
    assign start   = is_start(cpu_wr, cpu_sel, cpu_wdata[0]) && !busy;
    assign stat_rd = cpu_rd && (cpu_sel == SEL_STAT);

    flyby_dma_regs #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ld_addr    (ld_addr),
        .ld_cnt     (ld_cnt),
        .addr_wdata (cpu_wdata),
        .cnt_wdata  (cpu_wdata[CNT_W-1:0]),
        .step       (step),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last)
    );

    flyby_dma_watchdog #(
        .TIMEOUT (TIMEOUT)
    ) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .ack     (dev_ack),
        .expired (expired)
    );

    flyby_dma_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stat_rd  (stat_rd),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .ack      (dev_ack),
        .expired  (expired),
        .req      (dev_req),
        .step     (step),
        .stat     (stat),
        .irq      (irq)
    );

    assign dev_addr = cur_addr;

    always_comb begin
        unique case (cpu_sel)
            SEL_ADDR:  cpu_rdata = cur_addr;
            SEL_COUNT: cpu_rdata = {{CNT_PAD{1'b0}}, cur_cnt};
            SEL_STAT:  cpu_rdata = {{STAT_PAD{1'b0}}, stat};
            default:   cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int TIMEOUT    = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [1:0]        cpu_sel,
    input logic              dev_req,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_ack,
    input logic              irq
);
    localparam int NW = $clog2(TIMEOUT + 2);
    logic [NW-1:0] silent_q;

    always_ff @(posedge clk) begin
        if (rst || !dev_req || dev_ack) begin
            silent_q <= '0;
        end else begin
            silent_q <= silent_q + 1'b1;
        end
    end

    // R4
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_req && !dev_ack) |=> $stable(dev_addr));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_req && dev_ack) |=> (dev_addr == $past(dev_addr) + ADDR_W'(WORD_BYTES)));

    // R6
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !dev_req);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !cpu_wr && cpu_sel == 2'd3 && !dev_req) |=> !irq);

    // R10
    timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
        dev_req |-> (silent_q < NW'(TIMEOUT)));

    // R8
    busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_req && !dev_ack && cpu_wr && cpu_sel == 2'd0) |=> $stable(dev_addr));
endmodule

bind flyby_dma flyby_dma_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES),
    .TIMEOUT    (TIMEOUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr   (cpu_wr),
    .cpu_rd   (cpu_rd),
    .cpu_sel  (cpu_sel),
    .dev_req  (dev_req),
    .dev_addr (dev_addr),
    .dev_ack  (dev_ack),
    .irq      (irq)
);

// File: tb/flyby_dma_test.sv
module flyby_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        dev_req;
    logic [31:0] dev_addr;
    logic        dev_ack = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    // device responder settings
    int  resp_lat = 0;
    bit  resp_en = 1'b1;
    int  resp_ctr = 0;

    // reference model state
    logic [31:0] m_addr = '0;
    int          m_cnt = 0;
    bit          m_busy = 0, m_done = 0, m_err = 0, m_irq = 0;
    int          m_wait = 0;

    always #10 clk = ~clk;

    flyby_dma uut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_req(dev_req),
        .dev_addr(dev_addr), .dev_ack(dev_ack), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural model, updated on every rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_addr = '0; m_cnt = 0; m_busy = 0; m_done = 0; m_err = 0; m_irq = 0; m_wait = 0;
        end else begin
            if (cpu_rd && cpu_sel == 2'd3) m_irq = 0;
            if (!m_busy) begin
                if (cpu_wr && cpu_sel == 2'd0) m_addr = cpu_wdata;
                if (cpu_wr && cpu_sel == 2'd1) m_cnt = int'(cpu_wdata[15:0]);
                if (cpu_wr && cpu_sel == 2'd2 && cpu_wdata[0]) begin
                    m_err = 0;
                    if (m_cnt == 0) begin m_done = 1; m_irq = 1; end
                    else begin m_done = 0; m_busy = 1; m_wait = 0; end
                end
            end else if (dev_ack) begin
                m_addr = m_addr + 32'd4;
                if (m_cnt <= 4) begin
                    m_cnt = 0; m_busy = 0; m_done = 1; m_irq = 1;
                end else begin
                    m_cnt = m_cnt - 4;
                end
                m_wait = 0;
            end else if (m_wait == 63) begin
                m_busy = 0; m_err = 1; m_irq = 1; m_wait = 0;
            end else begin
                m_wait = m_wait + 1;
            end
        end
    end

    // device responder
    always @(negedge clk) begin
        if (dev_ack) begin
            dev_ack = 1'b0;
            resp_ctr = resp_lat;
        end else if (!dev_req) begin
            resp_ctr = resp_lat;
        end else if (resp_en) begin
            if (resp_ctr == 0) dev_ack = 1'b1;
            else resp_ctr = resp_ctr - 1;
        end
    end

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        #3;
        if (!rst) begin
            logic [31:0] exp_rd;
            case (cpu_sel)
                2'd0: exp_rd = m_addr;
                2'd1: exp_rd = 32'(m_cnt);
                2'd3: exp_rd = {29'd0, m_err, m_done, m_busy};
                default: exp_rd = '0;
            endcase
            check("R4 dev_req", {31'd0, dev_req}, {31'd0, m_busy});
            if (m_busy) check("R5 dev_addr", dev_addr, m_addr);
            check("R6 irq", {31'd0, irq}, {31'd0, m_irq});
            check("R2 cpu_rdata", cpu_rdata, exp_rd);
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = '0;
    endtask

    task automatic rd_status(output logic [31:0] v);
        @(negedge clk);
        cpu_sel = 2'd3; cpu_rd = 1'b1;
        #5 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] v);
        @(negedge clk);
        cpu_sel = sel;
        #5 v = cpu_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #5;
            if (!dev_req) break;
        end
    endtask

    task automatic run_xfer(input logic [31:0] a, input int c, input int lat);
        resp_lat = lat;
        wr(2'd0, a);
        wr(2'd1, 32'(c));
        wr(2'd2, 32'd1);
        wait_idle();
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R1: reset state
        check("R1 dev_req", {31'd0, dev_req}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        peek(2'd0, v); check("R1 addr", v, 32'd0);
        peek(2'd1, v); check("R1 count", v, 32'd0);
        peek(2'd3, v); check("R1 status", v, 32'd0);

        // R2: registers readable while idle
        wr(2'd0, 32'h0000_1000);
        peek(2'd0, v); check("R2 addr readback", v, 32'h0000_1000);
        wr(2'd1, 32'd16);
        peek(2'd1, v); check("R2 count readback", v, 32'd16);
        peek(2'd2, v); check("R2 ctrl reads zero", v, 32'd0);

        // R3: start asserts request with programmed address
        resp_lat = 0;
        wr(2'd2, 32'd1);
        #3;
        check("R3 req after start", {31'd0, dev_req}, 32'd1);
        check("R3 first address", dev_addr, 32'h0000_1000);
        wait_idle();
        // R6: done and irq after four words
        rd_status(v); check("R6 status done", v, 32'd2);
        peek(2'd0, v); check("R5 final addr", v, 32'h0000_1010);
        check("R9 irq cleared by status read", {31'd0, irq}, 32'd0);

        // R5 R6: odd count with slow device
        run_xfer(32'h0000_2000, 10, 3);
        peek(2'd0, v); check("R6 partial word addr", v, 32'h0000_200C);
        peek(2'd1, v); check("R5 count saturates", v, 32'd0);
        rd_status(v); check("R9 status done", v, 32'd2);

        // R7: zero count start
        wr(2'd1, 32'd0);
        wr(2'd2, 32'd1);
        #3;
        check("R7 irq on zero count", {31'd0, irq}, 32'd1);
        check("R7 no request", {31'd0, dev_req}, 32'd0);
        rd_status(v); check("R7 status done", v, 32'd2);

        // R8: writes during busy ignored
        resp_lat = 5;
        wr(2'd0, 32'h0000_3000);
        wr(2'd1, 32'd16);
        wr(2'd2, 32'd1);
        wr(2'd0, 32'hDEAD_0000);
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd1);
        wait_idle();
        peek(2'd0, v); check("R8 addr unaffected", v, 32'h0000_3010);
        peek(2'd1, v); check("R8 count unaffected", v, 32'd0);
        rd_status(v); check("R8 status", v, 32'd2);

        // R4: device answers just inside the limit
        run_xfer(32'h0000_4000, 8, 62);
        rd_status(v); check("R4 late ack accepted", v, 32'd2);

        // R10: device never answers
        resp_en = 1'b0;
        run_xfer(32'h0000_5000, 8, 0);
        check("R10 irq on timeout", {31'd0, irq}, 32'd1);
        peek(2'd0, v); check("R10 addr kept", v, 32'h0000_5000);
        peek(2'd1, v); check("R10 count kept", v, 32'd8);
        rd_status(v); check("R10 status error", v, 32'd4);
        resp_en = 1'b1;

        // R9: next start clears error
        run_xfer(32'h0000_6000, 4, 1);
        rd_status(v); check("R9 error cleared", v, 32'd2);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule